// File: doc/BRIEF.md
# Indirect-Addressed Host Register Port

This block is the byte-wide host side of an audio codec. The host bus is asynchronous. Two address lines pick one of four direct registers: an index pointer, a data window into a bank of indirect registers, a status byte, and a sample data port. The same strobes also carry DMA transfers. A DMA transfer is marked by an active-low playback or capture acknowledge, and chip select is not looked at during such a transfer. The block produces the two DMA request levels from the FIFO fill levels it is given. It drives the enable and the direction of an external bus transceiver. It holds three interrupt flags and drives a gated interrupt pin.

The read and write strobes pass through a synchroniser into the internal clock. Each access takes effect once, at the edge where its strobe rises, and uses the address, select and data values captured while the strobe was low. Read data is driven from the live pins and state for as long as the read strobe is low. The FIFO storage sits outside the block and is reached through level inputs, a push strobe with its data, a pop strobe and a head-of-queue byte.

Top module: `host_regport`

## Requirements
- R1: The address selects the direct register: 0 the index pointer, 1 the indexed data window, 2 status, 3 the sample data port. A read of address 0 returns the 5-bit index in bits 4:0, with bits 7:5 zero.
- R2: Reads and writes of address 1 reach the indirect register whose number was last written to address 0. Indexes 0 to 15 are plain 8-bit read/write registers.
- R3: A cycle with cs_n high and both acknowledges high has no effect. During such a read, dout is 0x00.
- R4: A write with pdak_n low pushes din into the playback FIFO, whatever the values of cs_n and adr. A read with cdak_n low returns cap_rdata and pops the capture FIFO, whatever the values of cs_n and adr. A chip-selected write to address 3 also pushes, and a chip-selected read of address 3 also returns cap_rdata and pops. A write with only cdak_n low pushes nothing.
- R5: cdrq is high exactly when cap_level is nonzero. pdrq is high exactly when play_level is below the FIFO depth (16).
- R6: dben_n is low exactly when a strobe is low together with cs_n low or with either acknowledge low. dbdir is low exactly when rd_n is low together with cs_n low or with either acknowledge low. Otherwise both are high.
- R7: A pulse on irq_evt bit 0, 1 or 2 (playback, capture, timer) sets the matching flag. int_pin is the OR of the flags gated by enable bit 1 of index 10. The status byte holds int_pin in bit 0, pdrq in bit 1, cdrq in bit 2 and the flags in bits 4, 5 and 6. All other status bits are zero.
- R8: Any write to status clears all flags. Writing index 24 clears each flag whose bit (4 to 6) is written zero, and leaves set each flag whose bit is written one. An event in the same cycle as a clear leaves its flag set. Index 24 reads the flags in bits 6:4.
- R9: Bit 6 of index 12 enables the extended set. While the bit is clear, indexes 16 to 31 read zero and ignore writes. While it is set, indexes 16 to 23 are read/write, index 24 is the flag register, and indexes 25 to 31 read zero and ignore writes.
- R10: An access is acted on exactly once, when its strobe rises, no matter how long the strobe was held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select for register and sample-port cycles, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| adr | input | 2 | Direct register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| pdak_n | input | 1 | Playback DMA acknowledge, active low |
| cdak_n | input | 1 | Capture DMA acknowledge, active low |
| pdrq | output | 1 | Playback DMA request |
| cdrq | output | 1 | Capture DMA request |
| dben_n | output | 1 | Transceiver enable, active low |
| dbdir | output | 1 | Transceiver direction, high host-to-device |
| play_level | input | 5 | Playback FIFO fill level |
| cap_level | input | 5 | Capture FIFO fill level |
| play_push | output | 1 | One-cycle playback push strobe |
| play_wdata | output | 8 | Byte pushed to playback FIFO |
| cap_pop | output | 1 | One-cycle capture pop strobe |
| cap_rdata | input | 8 | Head byte of capture FIFO |
| irq_evt | input | 3 | Event pulses: playback, capture, timer |
| int_pin | output | 1 | Host interrupt |

## Verification
The two functions that can meet in one cycle are the flag clear from a host write and the setting of a flag by an event. The bench raises an event pulse in exactly the clock cycle in which a status write, synchronised from its strobe, takes effect. A correct design must then still show that flag set in the status byte. A design that lets the clear win would lose the event, and the bench would see that flag as zero.

// File: rtl/host_regport.sv
module host_regport #(
  parameter int IDX_W       = 5,
  parameter int NBASE       = 16,
  parameter int NSTORE      = 24,
  parameter int FLAG_IDX    = 24,
  parameter int CTRL_IDX    = 10,
  parameter int MODE_IDX    = 12,
  parameter int IEN_BIT     = 1,
  parameter int MODE_BIT    = 6,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [1:0]       adr,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  input  logic             pdak_n,
  input  logic             cdak_n,
  output logic             pdrq,
  output logic             cdrq,
  output logic             dben_n,
  output logic             dbdir,
  input  logic [LVL_W-1:0] play_level,
  input  logic [LVL_W-1:0] cap_level,
  output logic             play_push,
  output logic [7:0]       play_wdata,
  output logic             cap_pop,
  input  logic [7:0]       cap_rdata,
  input  logic [2:0]       irq_evt,
  output logic             int_pin
);
  localparam logic [IDX_W-1:0] BASE_I = IDX_W'(NBASE);
  localparam logic [IDX_W-1:0] STOR_I = IDX_W'(NSTORE);
  localparam logic [IDX_W-1:0] FLAG_I = IDX_W'(FLAG_IDX);
  localparam int FLAG_LSB = 4;

  logic [SYNC_STAGES-1:0] rd_s, wr_s;
  logic       rd_q, wr_q;
  logic [1:0] lat_adr;
  logic       lat_cs_n, lat_pdak_n, lat_cdak_n;
  logic [7:0] lat_din;
  logic [IDX_W-1:0] idx;
  logic [7:0] bank [NSTORE];
  logic [2:0] flags;

  wire rd_syn  = rd_s[SYNC_STAGES-1];
  wire wr_syn  = wr_s[SYNC_STAGES-1];
  wire rd_rise = rd_syn & ~rd_q;
  wire wr_rise = wr_syn & ~wr_q;

  wire dma_cyc = ~lat_pdak_n | ~lat_cdak_n;
  wire pio_cyc = ~dma_cyc & ~lat_cs_n;

  wire do_push = wr_rise & ((dma_cyc & ~lat_pdak_n) | (pio_cyc & lat_adr == 2'd3));
  wire do_pop  = rd_rise & ((dma_cyc & ~lat_cdak_n) | (pio_cyc & lat_adr == 2'd3));
  wire idx_wr  = wr_rise & pio_cyc & (lat_adr == 2'd0);
  wire dat_wr  = wr_rise & pio_cyc & (lat_adr == 2'd1);
  wire st_wr   = wr_rise & pio_cyc & (lat_adr == 2'd2);

  wire ext_on  = bank[MODE_IDX][MODE_BIT];
  wire ien     = bank[CTRL_IDX][IEN_BIT];
  wire visible = (idx < BASE_I) | ext_on;
  wire bank_wr = dat_wr & (idx < STOR_I) & visible;
  wire flag_wr = dat_wr & (idx == FLAG_I) & ext_on;

  wire [2:0] fl_clr = st_wr ? 3'b111 :
                      flag_wr ? ~lat_din[FLAG_LSB +: 3] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s <= '1;
      wr_s <= '1;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_s <= {rd_s[SYNC_STAGES-2:0], rd_n};
      wr_s <= {wr_s[SYNC_STAGES-2:0], wr_n};
      rd_q <= rd_syn;
      wr_q <= wr_syn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_adr    <= 2'd0;
      lat_cs_n   <= 1'b1;
      lat_pdak_n <= 1'b1;
      lat_cdak_n <= 1'b1;
      lat_din    <= 8'h00;
    end else if (!rd_syn || !wr_syn) begin
      lat_adr    <= adr;
      lat_cs_n   <= cs_n;
      lat_pdak_n <= pdak_n;
      lat_cdak_n <= cdak_n;
      lat_din    <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      flags      <= 3'b000;
      play_push  <= 1'b0;
      cap_pop    <= 1'b0;
      play_wdata <= 8'h00;
      for (int i = 0; i < NSTORE; i++) bank[i] <= 8'h00;
    end else begin
      play_push <= do_push;
      cap_pop   <= do_pop;
      if (do_push) play_wdata <= lat_din;
      if (idx_wr) idx <= lat_din[IDX_W-1:0];
      if (bank_wr) bank[idx] <= lat_din;
      flags <= (flags & ~fl_clr) | irq_evt;
    end
  end

  logic [7:0] ind_val, dir_val;
  always_comb begin
    ind_val = 8'h00;
    if (idx < STOR_I) begin
      if (visible) ind_val = bank[idx];
    end else if (idx == FLAG_I && ext_on) begin
      ind_val[FLAG_LSB +: 3] = flags;
    end
  end

  always_comb begin
    case (adr)
      2'd0:    dir_val = {{(8-IDX_W){1'b0}}, idx};
      2'd1:    dir_val = ind_val;
      2'd2:    dir_val = {1'b0, flags, 1'b0, cdrq, pdrq, int_pin};
      default: dir_val = cap_rdata;
    endcase
  end

  assign dout = rd_n    ? 8'h00 :
                !cdak_n ? cap_rdata :
                !pdak_n ? 8'h00 :
                !cs_n   ? dir_val : 8'h00;

  wire qual = ~cs_n | ~pdak_n | ~cdak_n;
  assign dben_n  = ~((~rd_n | ~wr_n) & qual);
  assign dbdir   = ~(~rd_n & qual);
  assign cdrq    = cap_level != '0;
  assign pdrq    = play_level < LVL_W'(FIFO_DEPTH);
  assign int_pin = ien & (|flags);
endmodule

// File: rtl/host_regport_chk.sv
module host_regport_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dben_n,
  input logic             dbdir,
  input logic             play_push,
  input logic             cap_pop,
  input logic [IDX_W-1:0] idx,
  input logic             idx_wr,
  input logic [2:0]       flags,
  input logic [2:0]       irq_evt
);
  // R10
  push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_push |=> !play_push);

  // R10
  pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pop |=> !cap_pop);

  // R6
  dir_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbdir |-> !dben_n);

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> $past(idx_wr));

  for (genvar k = 0; k < 3; k++) begin : g_flag
    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[k]) |-> $past(irq_evt[k]));
  end
endmodule

bind host_regport host_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dben_n(dben_n), .dbdir(dbdir),
  .play_push(play_push), .cap_pop(cap_pop), .idx(idx), .idx_wr(idx_wr),
  .flags(flags), .irq_evt(irq_evt)
);

// File: tb/host_regport_test.sv
module host_regport_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, pdak_n = 1, cdak_n = 1;
  logic [1:0] adr = 0;
  logic [7:0] din = 0, cap_rdata = 8'h3C;
  logic [4:0] play_level = 0, cap_level = 0;
  logic [2:0] irq_evt = 0;
  logic [7:0] dout, play_wdata;
  logic pdrq, cdrq, dben_n, dbdir, play_push, cap_pop, int_pin;

  host_regport uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, pushes = 0, pops = 0;
  bit done = 0;
  logic [7:0] mem [24];
  logic [2:0] mflags = 0;

  always @(negedge clk) begin
    if (play_push) pushes++;
    if (cap_pop) pops++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mode_on();
    return mem[12][6];
  endfunction

  function automatic logic [7:0] exp_ind(input int i);
    if (i < 16) return mem[i];
    if (i < 24) return mode_on() ? mem[i] : 8'h00;
    if (i == 24 && mode_on()) return {1'b0, mflags, 4'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_status();
    logic ip;
    ip = mem[10][1] & (|mflags);
    return {1'b0, mflags, 1'b0, cap_level != 0, play_level < DEPTH, ip};
  endfunction

  task automatic cyc(input bit is_wr, input logic [1:0] a, input logic [7:0] d,
                     input bit cs, input bit pd, input bit cd, input int hold,
                     input logic [2:0] evt, output logic [7:0] rv);
    @(negedge clk); adr = a; din = d; cs_n = !cs; pdak_n = !pd; cdak_n = !cd;
    @(negedge clk); if (is_wr) wr_n = 0; else rd_n = 0;
    repeat (hold) @(negedge clk);
    rv = dout;
    if (is_wr) wr_n = 1; else rd_n = 1;
    @(negedge clk);
    @(negedge clk); irq_evt = evt;
    @(negedge clk); irq_evt = 0;
    repeat (3) @(negedge clk);
    cs_n = 1; pdak_n = 1; cdak_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] rv;
    cyc(1, a, d, 1, 0, 0, 3, 3'b0, rv);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    cyc(0, a, 8'h00, 1, 0, 0, 3, 3'b0, v);
  endtask

  task automatic wr_ind(input int i, input logic [7:0] v);
    bit m;
    m = mode_on();
    wr(2'd0, 8'(i));
    wr(2'd1, v);
    if (i < 16 || (m && i < 24)) mem[i] = v;
    if (i == 24 && m) mflags = mflags & v[6:4];
  endtask

  task automatic rd_ind(input string req, input int i);
    logic [7:0] v;
    wr(2'd0, 8'(i));
    rd(2'd1, v);
    chk(req, v, exp_ind(i));
  endtask

  task automatic pulse(input logic [2:0] e);
    @(negedge clk); irq_evt = e;
    @(negedge clk); irq_evt = 0;
    mflags = mflags | e;
    repeat (2) @(negedge clk);
  endtask

  task automatic probe(input bit r, input bit w, input bit c, input bit pd, input bit cd);
    @(negedge clk);
    adr = 2'd2; rd_n = !r; wr_n = !w; cs_n = !c; pdak_n = !pd; cdak_n = !cd;
    #1;
    chk("R6 dben_n", dben_n, !((r | w) & (c | pd | cd)));
    chk("R6 dbdir", dbdir, !(r & (c | pd | cd)));
    #1;
    rd_n = 1; wr_n = 1; cs_n = 1; pdak_n = 1; cdak_n = 1;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p0, q0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 24; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    chk("R3 idle dout", dout, 0);
    chk("R7 reset int", int_pin, 0);
    chk("R5 reset pdrq", pdrq, 1);
    chk("R5 reset cdrq", cdrq, 0);
    rd(2'd0, v); chk("R1 reset index", v, 0);

    play_level = 16; cap_level = 1; #1;
    chk("R5 full pdrq", pdrq, 0); chk("R5 cdrq one", cdrq, 1);
    play_level = 15; cap_level = 0; #1;
    chk("R5 pdrq 15", pdrq, 1); chk("R5 cdrq zero", cdrq, 0);
    play_level = 5;

    probe(0, 0, 1, 0, 0); probe(1, 0, 1, 0, 0); probe(0, 1, 1, 0, 0);
    probe(1, 0, 0, 0, 1); probe(0, 1, 0, 1, 0); probe(1, 1, 0, 0, 0);
    probe(0, 0, 0, 1, 1);

    wr(2'd0, 8'hF7);
    rd(2'd0, v); chk("R1 index readback", v, 8'h17);
    rd(2'd2, v); chk("R1 status read", v, exp_status());

    wr_ind(3, 8'hA5);
    wr(2'd0, 8'd9);
    cyc(1, 2'd0, 8'd3, 0, 0, 0, 3, 3'b0, v);
    rd(2'd0, v); chk("R3 unselected write ignored", v, 9);
    cyc(0, 2'd0, 8'h00, 0, 0, 0, 3, 3'b0, v);
    chk("R3 unselected read zero", v, 0);
    rd_ind("R2 indexed readback", 3);

    p0 = pushes;
    cyc(1, 2'd1, 8'hA7, 0, 1, 0, 3, 3'b0, v);
    chk("R4 dma push count", pushes - p0, 1);
    chk("R4 dma push data", play_wdata, 8'hA7);
    rd_ind("R4 dma write left bank", 3);
    p0 = pushes;
    cyc(1, 2'd3, 8'h11, 1, 0, 1, 3, 3'b0, v);
    chk("R4 capture-ack write no push", pushes - p0, 0);
    wr(2'd3, 8'h5E);
    chk("R4 pio push count", pushes - p0, 1);
    chk("R4 pio push data", play_wdata, 8'h5E);
    q0 = pops;
    cyc(0, 2'd2, 8'h00, 0, 0, 1, 3, 3'b0, v);
    chk("R4 dma read data", v, 8'h3C);
    chk("R4 dma pop count", pops - q0, 1);
    cap_rdata = 8'h81;
    rd(2'd3, v);
    chk("R4 pio read data", v, 8'h81);
    chk("R4 pio pop count", pops - q0, 2);

    p0 = pushes;
    cyc(1, 2'd0, 8'h44, 0, 1, 0, 20, 3'b0, v);
    chk("R10 long strobe one push", pushes - p0, 1);
    q0 = pops;
    cyc(0, 2'd0, 8'h00, 0, 0, 1, 25, 3'b0, v);
    chk("R10 long strobe one pop", pops - q0, 1);

    wr_ind(18, 8'h5A);
    rd_ind("R9 hidden read zero", 18);
    wr_ind(12, 8'h40);
    rd_ind("R9 hidden write was ignored", 18);
    wr_ind(18, 8'h5A);
    rd_ind("R9 extended readback", 18);
    wr_ind(27, 8'h33);
    rd_ind("R9 unimplemented zero", 27);
    wr_ind(12, 8'h00);
    rd_ind("R9 hidden again", 18);

    for (int n = 0; n < 80; n++) begin
      int i;
      logic [7:0] d;
      i = (n % 9 == 0) ? 12 : $urandom_range(0, 31);
      d = 8'($urandom);
      wr_ind(i, d);
      rd_ind("R2 random indexed", i);
      rd(2'd0, v);
      chk("R1 random index", v, i);
    end

    wr_ind(12, 8'h40);
    wr_ind(10, 8'h00);
    pulse(3'b001);
    rd(2'd2, v); chk("R7 flag without enable", v, exp_status());
    chk("R7 pin gated", int_pin, 0);
    wr_ind(10, 8'h02);
    chk("R7 pin enabled", int_pin, 1);
    rd(2'd2, v); chk("R7 status enabled", v, exp_status());
    pulse(3'b100);
    wr_ind(24, 8'h40);
    rd_ind("R8 zero-write clears one flag", 24);
    chk("R8 pin still set", int_pin, 1);
    wr(2'd2, 8'h00); mflags = 0;
    chk("R8 status write clears", int_pin, 0);
    rd(2'd2, v); chk("R8 status after clear", v, exp_status());
    pulse(3'b010);
    cyc(1, 2'd2, 8'h00, 1, 0, 0, 3, 3'b010, v);
    mflags = 3'b010;
    rd(2'd2, v); chk("R8 event beats clear", v, exp_status());
    chk("R8 event beats clear pin", int_pin, 1);
    wr(2'd2, 8'h00); mflags = 0;
    pulse(3'b001);
    wr_ind(12, 8'h00);
    wr_ind(24, 8'h00);
    rd(2'd2, v); chk("R9 hidden flag write ignored", v, exp_status());
    rd_ind("R9 hidden flag reg zero", 24);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule